// File: doc/BRIEF.md
# Masked Interrupt Status Aggregator

This block gathers interrupt events raised around a bus interface unit into one level interrupt request for the CPU. Descriptor-chain engines (inbound and outbound), a bus abort detector and an external device interrupt line each own a fixed bit of a status register. A pulse on an event input sets its bit, and the bit then stays set until software writes a one to it. The external line is asynchronous, so it passes through a two-stage synchroniser before it reaches the status register.

Software chooses which sources can interrupt with a per-bit mask register and switches the whole block on or off with a global enable bit. The pending set is the status ANDed with the mask. The block also reports the position of the lowest pending bit, which is the source that gets serviced first.

Registers are accessed through a plain 32-bit port. A write takes effect at the clock edge where it is presented. A read samples the addressed register at the edge where it is requested and returns the data one cycle later, with a valid strobe.

Top module: `irqagg_top`

## Requirements
- R1: After reset, the status, mask and enable registers read as zero, and `cpu_irq` and `pend_any` are low.
- R2: Register offsets are status 0x500, mask 0x504 and global enable 0x508, where only bit 0 of the enable register is stored. Reads of any other offset return zero. Read data appears on `rd_data` with `rd_valid` high in the cycle after `rd_en`.
- R3: An event pulse sets its status bit at the next clock edge. Inbound complete, OK, error and end-of-list set bits 0, 1, 2 and 3 (`desc_in_evt[3:0]`). The outbound events set bits 4 to 7 (`desc_out_evt[3:0]`). Inbound out-of-descriptors sets bit 9.
- R4: Writing status clears every bit written as one. Bits written as zero keep their value.
- R5: If an event arrives in the same cycle as a clearing write to its bit, the bit stays set.
- R6: `ext_irq_async` passes through two flip-flops and then sets status bit 25 at the third rising edge after it goes high. While the line stays high, the bit sets again after each clear.
- R7: A pulse on `bus_abort_evt` sets status bit 26.
- R8: A status read returns the raw latched bits whatever the mask holds.
- R9: `cpu_irq` is high exactly when enable bit 0 is set and (status AND mask) is non-zero.
- R10: `pend_any` shows whether (status AND mask) is non-zero, independent of the enable. `pend_idx` gives the lowest set pending bit position, or 0 when nothing is pending.
- R11: Unimplemented bits (all bits other than 0-7, 9, 25 and 26) read as zero in both status and mask, even after writes of all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 12 | Register byte offset |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid one cycle after rd_en |
| rd_valid | output | 1 | Read data valid |
| desc_in_evt | input | 4 | Inbound complete, OK, error, end-of-list pulses |
| desc_in_ood | input | 1 | Inbound out-of-descriptors pulse |
| desc_out_evt | input | 4 | Outbound complete, OK, error, end-of-list pulses |
| ext_irq_async | input | 1 | Asynchronous external device interrupt level |
| bus_abort_evt | input | 1 | Bus abort pulse |
| cpu_irq | output | 1 | Level interrupt to the CPU |
| pend_any | output | 1 | Some unmasked status bit is set |
| pend_idx | output | 5 | Lowest pending bit position |

## Verification
The bench targets a clearing write that lands together with an event on the same bit. A design that let the clear win would silently drop that interrupt. It counts the cycles the external line takes through the synchroniser, so a missing or extra stage shows up as the request rising one cycle off. It checks that the priority index picks the lowest pending bit, and that it stays valid while the global enable is off; an encoder that scanned from the top would report bit 26 instead of bit 0. It also writes all ones to status and mask, to catch unimplemented bits that were wrongly stored and would then raise phantom requests.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] OFF_STATUS = 12'h500;
    localparam logic [ADDR_W-1:0] OFF_MASK   = 12'h504;
    localparam logic [ADDR_W-1:0] OFF_ENABLE = 12'h508;

    localparam int BIT_IN_LO  = 0;
    localparam int BIT_OUT_LO = 4;
    localparam int BIT_IN_OOD = 9;
    localparam int BIT_EXT    = 25;
    localparam int BIT_ABORT  = 26;

    function automatic logic [DATA_W-1:0] impl_bits();
        logic [DATA_W-1:0] m;
        m = '0;
        for (int i = 0; i < 4; i++) begin
            m[BIT_IN_LO + i]  = 1'b1;
            m[BIT_OUT_LO + i] = 1'b1;
        end
        m[BIT_IN_OOD] = 1'b1;
        m[BIT_EXT]    = 1'b1;
        m[BIT_ABORT]  = 1'b1;
        return m;
    endfunction

    localparam logic [DATA_W-1:0] IMPL_MASK = impl_bits();
endpackage

// File: rtl/irqagg_sync.sv
module irqagg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], async_i};
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/irqagg_status.sv
module irqagg_status #(
    parameter int            W    = 32,
    parameter logic [W-1:0]  IMPL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] stat_o
);
    logic [W-1:0] stat_q;

    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= ((stat_q & ~clr_i) | set_i) & IMPL;
    end

    assign stat_o = stat_q;

    assert_w1c_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_i & ~set_i) != '0) |=> ((stat_q & $past(clr_i & ~set_i)) == '0));

    assert_event_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_i & IMPL) != '0) |=> ((stat_q & $past(set_i & IMPL)) == $past(set_i & IMPL)));
endmodule

// File: rtl/irqagg_prio.sv
module irqagg_prio #(
    parameter int W  = 32,
    localparam int IW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  req_i,
    output logic          any_o,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        any_o = |req_i;
        idx_o = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = IW'(i);
        end
    end

    assert_idx_is_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        any_o |-> req_i[idx_o]);

    assert_idx_is_lowest_R10: assert property (@(posedge clk) disable iff (!rst_n)
        any_o |-> ((req_i & ((W'(1) << idx_o) - W'(1))) == '0));
endmodule

// File: rtl/irqagg_top.sv
module irqagg_top
    import irqagg_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    input  logic [3:0]        desc_in_evt,
    input  logic              desc_in_ood,
    input  logic [3:0]        desc_out_evt,
    input  logic              ext_irq_async,
    input  logic              bus_abort_evt,
    output logic              cpu_irq,
    output logic              pend_any,
    output logic [IDX_W-1:0]  pend_idx
);
    logic              ext_sync;
    logic [DATA_W-1:0] set_vec;
    logic [DATA_W-1:0] clr_vec;
    logic [DATA_W-1:0] status;
    logic [DATA_W-1:0] mask_q;
    logic              gen_en_q;
    logic [DATA_W-1:0] pending;
    logic [DATA_W-1:0] rd_mux;

    irqagg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (ext_irq_async),
        .sync_o  (ext_sync)
    );

    always_comb begin
        set_vec = '0;
        set_vec[BIT_IN_LO  +: 4] = desc_in_evt;
        set_vec[BIT_OUT_LO +: 4] = desc_out_evt;
        set_vec[BIT_IN_OOD]      = desc_in_ood;
        set_vec[BIT_EXT]         = ext_sync;
        set_vec[BIT_ABORT]       = bus_abort_evt;
    end

    assign clr_vec = (wr_en && addr == OFF_STATUS) ? wr_data : '0;

    irqagg_status #(.W(DATA_W), .IMPL(IMPL_MASK)) u_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_vec),
        .clr_i  (clr_vec),
        .stat_o (status)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q   <= '0;
            gen_en_q <= 1'b0;
        end else if (wr_en) begin
            if (addr == OFF_MASK)   mask_q   <= wr_data & IMPL_MASK;
            if (addr == OFF_ENABLE) gen_en_q <= wr_data[0];
        end
    end

    assign pending = status & mask_q;

    irqagg_prio #(.W(DATA_W)) u_prio (
        .clk   (clk),
        .rst_n (rst_n),
        .req_i (pending),
        .any_o (pend_any),
        .idx_o (pend_idx)
    );

    assign cpu_irq = gen_en_q & pend_any;

    always_comb begin
        unique case (addr)
            OFF_STATUS: rd_mux = status;
            OFF_MASK:   rd_mux = mask_q;
            OFF_ENABLE: rd_mux = {{(DATA_W-1){1'b0}}, gen_en_q};
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) rd_data <= rd_mux;
        end
    end

    assert_status_impl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (status & ~IMPL_MASK) == '0);

    assert_irq_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq |-> (gen_en_q && (status & mask_q) != '0));

    assert_rd_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);
endmodule

// File: tb/irqagg_top_tb_top.sv
module irqagg_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        rd_valid;
    logic [3:0]  desc_in_evt = '0;
    logic        desc_in_ood = 1'b0;
    logic [3:0]  desc_out_evt = '0;
    logic        ext_irq_async = 1'b0;
    logic        bus_abort_evt = 1'b0;
    logic        cpu_irq;
    logic        pend_any;
    logic [4:0]  pend_idx;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [11:0] a;
        logic [31:0] v;
        string       tag;
    } exp_t;
    exp_t sb_q[$];

    always #4 clk = ~clk;

    irqagg_top dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid),
        .desc_in_evt(desc_in_evt), .desc_in_ood(desc_in_ood),
        .desc_out_evt(desc_out_evt), .ext_irq_async(ext_irq_async),
        .bus_abort_evt(bus_abort_evt), .cpu_irq(cpu_irq),
        .pend_any(pend_any), .pend_idx(pend_idx)
    );

    initial begin
        forever begin
            @(negedge clk);
            if (rd_valid) begin
                checks++;
                if (sb_q.size() == 0) begin
                    errors++;
                    $display("FAIL %s: unexpected read data %h expected none", "R2", rd_data);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    if (rd_data !== e.v) begin
                        errors++;
                        $display("FAIL %s: read %h got %h expected %h", e.tag, e.a, rd_data, e.v);
                    end
                end
            end
        end
    end

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
        exp_t e;
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        e.a = a; e.v = exp; e.tag = tag;
        sb_q.push_back(e);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pulse(input logic [3:0] in_e, input logic [3:0] out_e,
                         input logic ood, input logic abt);
        @(negedge clk);
        desc_in_evt = in_e; desc_out_evt = out_e; desc_in_ood = ood; bus_abort_evt = abt;
        @(negedge clk);
        desc_in_evt = '0; desc_out_evt = '0; desc_in_ood = 1'b0; bus_abort_evt = 1'b0;
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk({31'd0, cpu_irq}, 32'd0, "R1 cpu_irq");
        chk({31'd0, pend_any}, 32'd0, "R1 pend_any");
        rd(12'h500, 32'h0, "R1 status");
        rd(12'h504, 32'h0, "R1 mask");
        rd(12'h508, 32'h0, "R1 enable");
        // R3 bit map
        pulse(4'b0101, 4'b0000, 1'b0, 1'b0);
        rd(12'h500, 32'h0000_0005, "R3 inbound");
        pulse(4'b0000, 4'b1010, 1'b0, 1'b0);
        rd(12'h500, 32'h0000_00A5, "R3 outbound");
        pulse(4'b0000, 4'b0000, 1'b1, 1'b0);
        rd(12'h500, 32'h0000_02A5, "R3 ood");
        // R7 abort
        pulse(4'b0000, 4'b0000, 1'b0, 1'b1);
        rd(12'h500, 32'h0400_02A5, "R7 abort");
        // R8 raw read with zero mask
        rd(12'h500, 32'h0400_02A5, "R8 raw");
        chk({31'd0, pend_any}, 32'd0, "R8 pend_any masked");
        // R4 write one clears, zero keeps
        wr(12'h500, 32'h0000_0004);
        rd(12'h500, 32'h0400_02A1, "R4 clear one");
        wr(12'h500, 32'h0000_0000);
        rd(12'h500, 32'h0400_02A1, "R4 zero keeps");
        // R11 unimplemented bits
        wr(12'h504, 32'hFFFF_FFFF);
        rd(12'h504, 32'h0600_02FF, "R11 mask");
        wr(12'h508, 32'hFFFF_FFFF);
        rd(12'h508, 32'h0000_0001, "R2 enable bit0");
        // R9 / R10
        chk({31'd0, cpu_irq}, 32'd1, "R9 irq on");
        chk({27'd0, pend_idx}, 32'd0, "R10 lowest idx");
        wr(12'h504, 32'h0400_0000);
        chk({27'd0, pend_idx}, 32'd26, "R10 idx abort");
        wr(12'h508, 32'h0);
        chk({31'd0, cpu_irq}, 32'd0, "R9 enable off");
        chk({31'd0, pend_any}, 32'd1, "R10 pend_any without enable");
        wr(12'h508, 32'h1);
        chk({31'd0, cpu_irq}, 32'd1, "R9 enable on");
        wr(12'h500, 32'hFFFF_FFFF);
        chk({31'd0, cpu_irq}, 32'd0, "R9 all cleared");
        rd(12'h500, 32'h0, "R11 status after all-ones clear");
        // R2 unmapped offsets
        rd(12'h50C, 32'h0, "R2 unmapped 50C");
        rd(12'h000, 32'h0, "R2 unmapped 000");
        // R5 event wins over clear
        @(negedge clk);
        wr_en = 1'b1; addr = 12'h500; wr_data = 32'h1; desc_in_evt = 4'b0001;
        @(negedge clk);
        wr_en = 1'b0; desc_in_evt = '0;
        rd(12'h500, 32'h1, "R5 set wins");
        wr(12'h500, 32'h1);
        rd(12'h500, 32'h0, "R5 later clear");
        // R6 external line synchroniser
        wr(12'h504, 32'h0200_0000);
        @(negedge clk);
        ext_irq_async = 1'b1;
        @(negedge clk);
        chk({31'd0, cpu_irq}, 32'd0, "R6 after edge 1");
        @(negedge clk);
        chk({31'd0, cpu_irq}, 32'd0, "R6 after edge 2");
        @(negedge clk);
        chk({31'd0, cpu_irq}, 32'd1, "R6 after edge 3");
        wr(12'h500, 32'h0200_0000);
        rd(12'h500, 32'h0200_0000, "R6 level re-sets");
        @(negedge clk);
        ext_irq_async = 1'b0;
        repeat (3) @(negedge clk);
        wr(12'h500, 32'h0200_0000);
        rd(12'h500, 32'h0, "R6 cleared after drop");
        chk({31'd0, cpu_irq}, 32'd0, "R6 irq low");
        repeat (3) @(negedge clk);
        if (sb_q.size() != 0) begin
            errors++;
            $display("FAIL R2: pending reads %0d expected 0", sb_q.size());
        end
        finish_run();
    end
endmodule